// File: doc/BRIEF.md
# SAR Converter Conversion and Bus Controller

This block is the digital side of a 14-bit successive-approximation converter that presents a 15-bit parallel bus. An asynchronous, active-low convert-start pin is brought into the clock domain by a synchroniser. A falling edge on it captures the analog sample and starts a conversion. While the conversion runs, the active-low busy output is held low. A behavioural core model stands in for the analog converter. It latches the presented sample word and returns it as the result after a fixed number of clocks, `CONV_CYCLES`.

Two mode pins select when a finished result reaches the output register. In immediate mode the register takes the result in the same clock edge that releases busy. In deferred mode the result is parked in a pending register and only moves to the output register at the next accepted convert-start edge, so a read always returns the previous sample. A read drives the bus only while chip-select and read-strobe are both low. Chip-select may be tied permanently low. An offset word is written over the same bus with a write strobe: the word is captured on the strobe's falling edge if chip-select is low at that moment.

The controller has two states. `ST_IDLE` waits for a convert-start edge. The transition *accept* moves it to `ST_CONVERT`, drops busy and starts the core. `ST_CONVERT` waits for the core's done pulse. The transition *finish* returns it to `ST_IDLE`, raises busy and commits the result. A convert-start edge seen in `ST_CONVERT` is a *stray* start: it causes no transition and only sets a sticky error flag.

Top module: `sar_bus_ctrl`

## Requirements
- R1: A falling edge on `cnv_start_n` is detected after a two-flop synchroniser. Busy goes low on the third rising clock edge after the pin falls, and the sample word present then is captured.
- R2: `busy_n` stays low for exactly `CONV_CYCLES` clock cycles per accepted conversion and then returns high.
- R3: `mode_sel` = 2'b10 selects deferred mode. 2'b01 selects immediate mode, and the unused codes 2'b00 and 2'b11 also behave as immediate mode.
- R4: In immediate mode, a read taken once `busy_n` is high again returns the sample just converted.
- R5: In deferred mode, a read after a conversion returns the sample of the conversion before it. After reset that value is 0.
- R6: `dbus_oe` is 1 and `dbus_out` carries the output register only while `cs_n` and `rd_n` are both low. Otherwise `dbus_oe` is 0 and `dbus_out` is all zeros.
- R7: A convert-start edge that arrives while busy is low is ignored. The busy length and the result are those of the running conversion. The edge sets `overlap_err`, which stays set until reset.
- R8: `rst_n` low aborts any conversion and forces busy high at once. It clears the output and pending registers, the offset register and `overlap_err`. No result from an aborted conversion is committed.
- R9: On a falling edge of `wr_strobe`, after synchronisation, with `cs_n` low, the 15-bit `bus_in` word is stored in `offset_q`. With `cs_n` high the strobe has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| cnv_start_n | input | 1 | Asynchronous convert-start, falling edge starts a conversion |
| mode_sel | input | 2 | Latency mode, bit 1 is MODE2 and bit 0 is MODE1 |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| wr_strobe | input | 1 | Offset write strobe, latches on falling edge |
| bus_in | input | DATA_W | Word driven onto the bus for offset writes |
| ana_sample | input | DATA_W | Sample value handed to the core model |
| busy_n | output | 1 | Low while a conversion runs |
| dbus_out | output | DATA_W | Read data, zero while not driven |
| dbus_oe | output | 1 | Bus output enable (tri-state control) |
| offset_q | output | DATA_W | Stored offset word |
| overlap_err | output | 1 | Sticky flag for a convert-start during busy |

## Verification
The checker watches these on every cycle: the exact busy length, measured with a counter rather than a deep delay; that busy only falls after a detected start edge; the output-register rule when busy rises in each mode; the bus gating; the stray-start flag and its stickiness; and the offset capture. The reset abort, the synchroniser latency seen at the pins, the result that is missing after an aborted conversion, and the one-sample lag across two successive deferred conversions can only be shown by the bench's scenarios. The bench runs those, plus a vector table that covers all four mode codes.

// File: rtl/sarbus_pkg.sv
package sarbus_pkg;

    typedef enum logic [0:0] {
        ST_IDLE    = 1'b0,
        ST_CONVERT = 1'b1
    } conv_state_t;

    typedef enum logic [1:0] {
        MODE_RSVD_LO   = 2'b00,
        MODE_IMMEDIATE = 2'b01,
        MODE_DEFERRED  = 2'b10,
        MODE_RSVD_HI   = 2'b11
    } mode_code_t;

    // Only the deferred code changes latency; every other code acts as immediate (R3)
    function automatic logic mode_is_deferred(input logic [1:0] code);
        return code == MODE_DEFERRED;
    endfunction

endpackage

// File: rtl/sarbus_edge_sync.sv
module sarbus_edge_sync #(
    parameter int   STAGES     = 2,
    parameter logic IDLE_LEVEL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic fall
);
    localparam int LAST = STAGES;

    logic [LAST:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {(LAST + 1){IDLE_LEVEL}};
        end else begin
            chain_q <= {chain_q[LAST-1:0], din};
        end
    end

    // Synchronised level is chain_q[LAST-1]; chain_q[LAST] is its previous value
    assign fall = chain_q[LAST] & ~chain_q[LAST-1];

endmodule

// File: rtl/sarbus_core_stub.sv
module sarbus_core_stub #(
    parameter int DATA_W      = 15,
    parameter int CONV_CYCLES = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] sample_in,
    output logic [DATA_W-1:0] result,
    output logic              done
);
    localparam int CNT_W = $clog2(CONV_CYCLES + 1);

    logic [CNT_W-1:0]  remain_q;
    logic [DATA_W-1:0] held_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain_q <= '0;
            held_q   <= '0;
        end else if (start) begin
            remain_q <= CNT_W'(CONV_CYCLES);
            held_q   <= sample_in;
        end else if (remain_q != '0) begin
            remain_q <= remain_q - CNT_W'(1);
        end
    end

    assign done   = (remain_q == CNT_W'(1));
    assign result = held_q;

endmodule

// File: rtl/sar_bus_ctrl.sv
module sar_bus_ctrl
    import sarbus_pkg::*;
#(
    parameter int DATA_W      = 15,
    parameter int CONV_CYCLES = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnv_start_n,
    input  logic [1:0]        mode_sel,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_strobe,
    input  logic [DATA_W-1:0] bus_in,
    input  logic [DATA_W-1:0] ana_sample,
    output logic              busy_n,
    output logic [DATA_W-1:0] dbus_out,
    output logic              dbus_oe,
    output logic [DATA_W-1:0] offset_q,
    output logic              overlap_err
);

    logic              start_fall;
    logic              wr_fall;
    logic              core_done;
    logic [DATA_W-1:0] core_result;

    conv_state_t       state_q, state_d;
    logic              busy_n_q;
    logic              err_q;
    logic [DATA_W-1:0] data_q;
    logic [DATA_W-1:0] pend_q;
    logic [DATA_W-1:0] ofs_q;

    logic              accept_start;
    logic              finish_conv;
    logic              stray_start;
    logic              defer_mode;

    sarbus_edge_sync #(
        .STAGES     (SYNC_STAGES),
        .IDLE_LEVEL (1'b1)
    ) u_start_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (cnv_start_n),
        .fall  (start_fall)
    );

    sarbus_edge_sync #(
        .STAGES     (SYNC_STAGES),
        .IDLE_LEVEL (1'b0)
    ) u_wr_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (wr_strobe),
        .fall  (wr_fall)
    );

    sarbus_core_stub #(
        .DATA_W      (DATA_W),
        .CONV_CYCLES (CONV_CYCLES)
    ) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (accept_start),
        .sample_in (ana_sample),
        .result    (core_result),
        .done      (core_done)
    );

    assign defer_mode   = mode_is_deferred(mode_sel);
    assign accept_start = (state_q == ST_IDLE)    && start_fall;
    assign finish_conv  = (state_q == ST_CONVERT) && core_done;
    assign stray_start  = (state_q == ST_CONVERT) && start_fall;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: accept (IDLE->CONVERT), finish (CONVERT->IDLE)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start_fall) state_d = ST_CONVERT;
            ST_CONVERT: if (core_done)  state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Registered outputs and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_n_q <= 1'b1;
            err_q    <= 1'b0;
            data_q   <= '0;
            pend_q   <= '0;
        end else begin
            if (accept_start) begin
                busy_n_q <= 1'b0;
                if (defer_mode) begin
                    data_q <= pend_q;
                end
            end
            if (finish_conv) begin
                busy_n_q <= 1'b1;
                pend_q   <= core_result;
                if (!defer_mode) begin
                    data_q <= core_result;
                end
            end
            if (stray_start) begin
                err_q <= 1'b1;
            end
        end
    end

    // Offset register write path
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ofs_q <= '0;
        end else if (wr_fall && !cs_n) begin
            ofs_q <= bus_in;
        end
    end

    assign busy_n      = busy_n_q;
    assign overlap_err = err_q;
    assign offset_q    = ofs_q;
    assign dbus_oe     = ~cs_n & ~rd_n;
    assign dbus_out    = dbus_oe ? data_q : '0;

endmodule

// File: rtl/sar_bus_ctrl_chk.sv
module sar_bus_ctrl_chk #(
    parameter int DATA_W      = 15,
    parameter int CONV_CYCLES = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy_n,
    input logic              start_fall,
    input logic              wr_fall,
    input logic              cs_n,
    input logic [1:0]        mode_sel,
    input logic [DATA_W-1:0] core_result,
    input logic [DATA_W-1:0] data_q,
    input logic              dbus_oe,
    input logic [DATA_W-1:0] dbus_out,
    input logic              overlap_err,
    input logic [DATA_W-1:0] bus_in,
    input logic [DATA_W-1:0] offset_q
);
    int low_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_run <= 0;
        end else if (!busy_n) begin
            low_run <= low_run + 1;
        end else begin
            low_run <= 0;
        end
    end

    p_busy_after_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_n) |-> $past(start_fall));

    p_busy_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_n) |-> (low_run == CONV_CYCLES));

    // R3: codes other than 2'b10 take the immediate path
    p_immediate_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy_n) && ($past(mode_sel) != 2'b10)) |-> (data_q == $past(core_result)));

    p_deferred_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy_n) && ($past(mode_sel) == 2'b10)) |-> $stable(data_q));

    p_read_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dbus_oe |-> (dbus_out == data_q));

    p_read_float_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !dbus_oe |-> (dbus_out == '0));

    p_stray_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_n && start_fall) |=> overlap_err);

    p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        overlap_err |=> overlap_err);

    p_offset_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fall && !cs_n) |=> (offset_q == $past(bus_in)));

endmodule

bind sar_bus_ctrl sar_bus_ctrl_chk #(
    .DATA_W      (DATA_W),
    .CONV_CYCLES (CONV_CYCLES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy_n      (busy_n),
    .start_fall  (start_fall),
    .wr_fall     (wr_fall),
    .cs_n        (cs_n),
    .mode_sel    (mode_sel),
    .core_result (core_result),
    .data_q      (data_q),
    .dbus_oe     (dbus_oe),
    .dbus_out    (dbus_out),
    .overlap_err (overlap_err),
    .bus_in      (bus_in),
    .offset_q    (offset_q)
);

// File: tb/sar_bus_ctrl_tb.sv
module sar_bus_ctrl_tb;
    localparam int DATA_W = 15;
    localparam int NCONV  = 12;
    localparam int NVEC   = 6;

    // {mode_sel, first sample, second sample}
    localparam logic [31:0] VEC [0:NVEC-1] = '{
        {2'b01, 15'h7FFF, 15'h0001},
        {2'b10, 15'h2AAA, 15'h5555},
        {2'b00, 15'h0000, 15'h4321},
        {2'b11, 15'h1357, 15'h7FFE},
        {2'b10, 15'h7FFF, 15'h0000},
        {2'b01, 15'h3FFF, 15'h4000}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cnv_start_n = 1'b1;
    logic [1:0]        mode_sel = 2'b01;
    logic              cs_n = 1'b1;
    logic              rd_n = 1'b1;
    logic              wr_strobe = 1'b0;
    logic [DATA_W-1:0] bus_in = '0;
    logic [DATA_W-1:0] ana_sample = '0;
    logic              busy_n;
    logic [DATA_W-1:0] dbus_out;
    logic              dbus_oe;
    logic [DATA_W-1:0] offset_q;
    logic              overlap_err;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    sar_bus_ctrl #(
        .DATA_W      (DATA_W),
        .CONV_CYCLES (NCONV),
        .SYNC_STAGES (2)
    ) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cnv_start_n (cnv_start_n),
        .mode_sel    (mode_sel),
        .cs_n        (cs_n),
        .rd_n        (rd_n),
        .wr_strobe   (wr_strobe),
        .bus_in      (bus_in),
        .ana_sample  (ana_sample),
        .busy_n      (busy_n),
        .dbus_out    (dbus_out),
        .dbus_oe     (dbus_oe),
        .offset_q    (offset_q),
        .overlap_err (overlap_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cnv_start_n = 1'b1;
        cs_n = 1'b1;
        rd_n = 1'b1;
        wr_strobe = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic start_pulse(input logic [DATA_W-1:0] s);
        @(negedge clk);
        ana_sample = s;
        cnv_start_n = 1'b0;
        repeat (2) @(negedge clk);
        cnv_start_n = 1'b1;
    endtask

    // Counts negedge samples with busy low; optionally fires a second start mid-way
    task automatic count_busy(input bit inject, input logic [DATA_W-1:0] inj, output int cnt);
        cnt = 0;
        for (int i = 0; i < 500; i++) begin
            @(negedge clk);
            if (!busy_n) begin
                cnt++;
                if (inject && cnt == 4) begin
                    ana_sample = inj;
                    cnv_start_n = 1'b0;
                end
                if (inject && cnt == 6) cnv_start_n = 1'b1;
            end else if (cnt > 0) begin
                break;
            end
        end
    endtask

    task automatic read_bus(output logic [DATA_W-1:0] v, output logic oe);
        @(negedge clk);
        cs_n = 1'b0;
        rd_n = 1'b0;
        #1;
        v = dbus_out;
        oe = dbus_oe;
        cs_n = 1'b1;
        rd_n = 1'b1;
    endtask

    task automatic write_ofs(input logic [DATA_W-1:0] w, input logic cs_level);
        @(negedge clk);
        bus_in = w;
        cs_n = cs_level;
        wr_strobe = 1'b1;
        repeat (3) @(negedge clk);
        wr_strobe = 1'b0;
        repeat (4) @(negedge clk);
        cs_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=0x0 expected=0x1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [DATA_W-1:0] rv;
        logic              roe;
        int                cnt;

        // Reset state (R8, R6)
        do_reset();
        chk(busy_n == 1'b1, "R8 busy high after reset", int'(busy_n), 1);
        chk(overlap_err == 1'b0, "R8 flag clear after reset", int'(overlap_err), 0);
        chk(offset_q == '0, "R8 offset clear after reset", int'(offset_q), 0);
        chk(dbus_oe == 1'b0, "R6 bus idle not driven", int'(dbus_oe), 0);
        read_bus(rv, roe);
        chk(rv == '0 && roe, "R8 output register zero after reset", int'(rv), 0);

        // R1: synchroniser latency seen at busy
        @(negedge clk);
        ana_sample = 15'h0246;
        cnv_start_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(busy_n == 1'b1, "R1 busy still high two edges after start", int'(busy_n), 1);
        cnv_start_n = 1'b1;
        @(negedge clk);
        chk(busy_n == 1'b0, "R1 busy low on third edge", int'(busy_n), 0);
        count_busy(1'b0, '0, cnt);
        read_bus(rv, roe);
        chk(rv == 15'h0246, "R1 captured sample", int'(rv), 32'h0246);

        // Vector table: R2, R3, R4, R5
        for (int v = 0; v < NVEC; v++) begin
            logic [1:0]        m;
            logic [DATA_W-1:0] a, b, e1, e2;
            string             tag;
            m = VEC[v][31:30];
            a = VEC[v][29:15];
            b = VEC[v][14:0];
            e1 = (m == 2'b10) ? '0 : a;
            e2 = (m == 2'b10) ? a : b;
            tag = (m == 2'b10) ? "R5 deferred" : ((m == 2'b01) ? "R4 immediate" : "R3 unused code as immediate");
            do_reset();
            mode_sel = m;
            start_pulse(a);
            count_busy(1'b0, '0, cnt);
            chk(cnt == NCONV, "R2 busy length first", cnt, NCONV);
            read_bus(rv, roe);
            chk(rv == e1, tag, int'(rv), int'(e1));
            start_pulse(b);
            count_busy(1'b0, '0, cnt);
            chk(cnt == NCONV, "R2 busy length second", cnt, NCONV);
            read_bus(rv, roe);
            chk(rv == e2, tag, int'(rv), int'(e2));
        end

        // R6: only one of the two strobes low
        do_reset();
        mode_sel = 2'b01;
        start_pulse(15'h1111);
        count_busy(1'b0, '0, cnt);
        @(negedge clk);
        cs_n = 1'b0;
        rd_n = 1'b1;
        #1;
        chk(dbus_oe == 1'b0 && dbus_out == '0, "R6 rd high keeps bus off", int'(dbus_out), 0);
        cs_n = 1'b1;
        rd_n = 1'b0;
        #1;
        chk(dbus_oe == 1'b0 && dbus_out == '0, "R6 cs high keeps bus off", int'(dbus_out), 0);
        rd_n = 1'b1;
        read_bus(rv, roe);
        chk(roe && rv == 15'h1111, "R6 both low drives register", int'(rv), 32'h1111);

        // R7: stray start during busy
        do_reset();
        mode_sel = 2'b01;
        start_pulse(15'h0AAA);
        count_busy(1'b1, 15'h0555, cnt);
        chk(cnt == NCONV, "R7 busy length unchanged by stray start", cnt, NCONV);
        chk(overlap_err == 1'b1, "R7 flag set", int'(overlap_err), 1);
        read_bus(rv, roe);
        chk(rv == 15'h0AAA, "R7 result of running conversion", int'(rv), 32'h0AAA);
        start_pulse(15'h0F0F);
        count_busy(1'b0, '0, cnt);
        chk(overlap_err == 1'b1, "R7 flag sticky", int'(overlap_err), 1);
        read_bus(rv, roe);
        chk(rv == 15'h0F0F, "R7 later conversion normal", int'(rv), 32'h0F0F);

        // R8: reset mid-conversion
        start_pulse(15'h3C3C);
        repeat (4) @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk(busy_n == 1'b1, "R8 busy forced high", int'(busy_n), 1);
        chk(overlap_err == 1'b0, "R8 flag cleared", int'(overlap_err), 0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (NCONV + 4) @(negedge clk);
        chk(busy_n == 1'b1, "R8 no conversion resumes", int'(busy_n), 1);
        read_bus(rv, roe);
        chk(rv == '0, "R8 aborted result not committed", int'(rv), 0);

        // R9: offset writes
        write_ofs(15'h0515, 1'b0);
        chk(offset_q == 15'h0515, "R9 write with cs low", int'(offset_q), 32'h0515);
        write_ofs(15'h7777, 1'b1);
        chk(offset_q == 15'h0515, "R9 write with cs high ignored", int'(offset_q), 32'h0515);
        do_reset();
        chk(offset_q == '0, "R8 offset cleared by reset", int'(offset_q), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule